// File: doc/BRIEF.md
# Per-Channel Buffer Segment Allocator

This block divides a shared pool of 508 fixed-size buffer segments among the logical channels of one ingress port. Each segment holds one 256-byte burst. A register write port sets three things: how many channels exist, how many segments each channel owns, and a per-channel factor. The factor sets how early that channel signals backpressure. Software picks a channel-count code once after reset. The code fixes both the number of legal channel indices and the largest allocation any one channel may hold. After that first accepted write the code is frozen.

While running, the datapath sends consume strobes when it stores a burst for a channel and release strobes when it forwards one. The block keeps a free-segment count for every enabled channel. Each channel's threshold is its factor multiplied by a power-of-two scale, and the scale depends on the size of that channel's allocation. A channel raises backpressure while its free count is at or below this threshold. Illegal configuration and illegal strobes are rejected and reported as one-cycle error pulses.

Top module: `seg_alloc_top`

## Requirements
- R1: After reset the channel-count code is 3 (16 channels), all allocations, factors and enables are zero, every backpressure bit is low and every error output is low.
- R2: A write with cfg_sel=0 sets the channel-count code from cfg_data[2:0]. Codes 0..5 give 1/4/8/16/32/64 channels and per-channel caps of 508/256/128/64/32/16 segments, and the first accepted code locks. Later code writes are ignored with no error. Codes 6 and 7 are discarded, do not lock, and pulse err_alloc.
- R3: A channel-indexed write (cfg_sel 1, 2 or 3), consume or release whose channel index is at or above the configured channel count is discarded and pulses err_chan.
- R4: An allocation write (cfg_sel=1, cfg_data = segment count M) to an enabled channel is discarded and pulses err_alloc.
- R5: An allocation write is discarded and pulses err_alloc if M exceeds the per-channel cap of the current code, or if the sum of all allocations would exceed 508. The sum is computed with this channel's old value replaced by the new one.
- R6: A write with cfg_sel=3 and cfg_data[0]=1 enables the channel and loads its free count with M. With cfg_data[0]=0 it disables the channel, and a disabled channel never shows backpressure.
- R7: A consume on an enabled channel decrements its free count. At zero free segments the consume is ignored and err_ovf pulses. A consume on a disabled channel is ignored with no error.
- R8: A release on an enabled channel increments its free count. When the free count already equals M the release is ignored and err_unf pulses. A release on a disabled channel is ignored with no error.
- R9: The scale N is 16 for M in 256..508, 8 for 128..255, 4 for 64..127, 2 for 32..63 and 1 for 0..31. The threshold is N times the factor written with cfg_sel=2 (cfg_data[4:0]).
- R10: bp[i] is high exactly when channel i is enabled and its free count is at or below its threshold. It follows state and factor changes in the same cycle they are registered.
- R11: Each error output is a one-cycle pulse in the cycle after the clock edge that samples the offending request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 code, 1 allocation, 2 factor, 3 enable |
| cfg_ch | input | 6 | Channel index of the write |
| cfg_data | input | 9 | Write data |
| cons_vld | input | 1 | Consume strobe (one segment taken) |
| cons_ch | input | 6 | Channel of the consume |
| rel_vld | input | 1 | Release strobe (one segment returned) |
| rel_ch | input | 6 | Channel of the release |
| bp | output | 64 | Per-channel backpressure |
| err_chan | output | 1 | Channel index out of range pulse |
| err_alloc | output | 1 | Rejected allocation or code pulse |
| err_ovf | output | 1 | Consume with no free segment pulse |
| err_unf | output | 1 | Release beyond allocation pulse |

## Verification
The hardest situations to reach are the scale boundaries. Each one only shows when an allocation sits on either side of a power of two while the pool sum stays legal. The stimulus first returns other channels' segments to the pool by disabling and zeroing them. It then walks one channel through the allocations 31/32, 63/64, 127/128 and 255/256 with a factor of 16. That factor makes backpressure appear right after enable only when the larger scale applies. The widest scale band with the full 508-segment allocation needs the single-channel code, and the code locks once written. A second reset is therefore used to reach it, and the bench steps the free count across a threshold of 496.

// File: rtl/segalloc_pkg.sv
package segalloc_pkg;

  typedef enum logic [1:0] {
    SEL_CODE  = 2'd0,
    SEL_ALLOC = 2'd1,
    SEL_FACT  = 2'd2,
    SEL_EN    = 2'd3
  } cfg_sel_e;

  localparam logic [2:0] CODE_RESET = 3'd3;
  localparam logic [2:0] CODE_MAX   = 3'd5;

  // Number of legal channel indices for a channel-count code.
  function automatic int unsigned chans_of_code(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 4;
      3'd2:    return 8;
      3'd3:    return 16;
      3'd4:    return 32;
      3'd5:    return 64;
      default: return 0;
    endcase
  endfunction

  // Largest allocation a single channel may hold under a code.
  function automatic int unsigned cap_of_code(input logic [2:0] code);
    case (code)
      3'd0:    return 508;
      3'd1:    return 256;
      3'd2:    return 128;
      3'd3:    return 64;
      3'd4:    return 32;
      3'd5:    return 16;
      default: return 0;
    endcase
  endfunction

  // log2 of the threshold scale, chosen from the allocation's range.
  function automatic logic [2:0] scale_shift(input logic [8:0] m);
    if (m[8])      return 3'd4;
    else if (m[7]) return 3'd3;
    else if (m[6]) return 3'd2;
    else if (m[5]) return 3'd1;
    else           return 3'd0;
  endfunction

endpackage

// File: rtl/seg_cfg.sv
module seg_cfg
  import segalloc_pkg::*;
#(
  parameter int MAX_CH    = 64,
  parameter int FACT_W    = 5,
  parameter int POOL_SEGS = 508,
  parameter int CH_W      = 6,
  parameter int SEG_W     = 9
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_we,
  input  logic [1:0]                       cfg_sel,
  input  logic [CH_W-1:0]                  cfg_ch,
  input  logic [SEG_W-1:0]                 cfg_data,
  output logic [2:0]                       code,
  output logic                             locked,
  output logic [CH_W:0]                    ch_limit,
  output logic [MAX_CH-1:0][SEG_W-1:0]     alloc,
  output logic [MAX_CH-1:0][FACT_W-1:0]    factor,
  output logic [MAX_CH-1:0]                en,
  output logic [MAX_CH-1:0]                load_vec,
  output logic [SEG_W:0]                   total,
  output logic                             ev_chan,
  output logic                             ev_alloc
);

  logic [2:0]                    code_q;
  logic                          lock_q;
  logic [MAX_CH-1:0][SEG_W-1:0]  alloc_q;
  logic [MAX_CH-1:0][FACT_W-1:0] fact_q;
  logic [MAX_CH-1:0]             en_q;
  logic [SEG_W:0]                total_q;

  cfg_sel_e sel;
  logic     ch_ok;
  logic     wr_code, wr_alloc, wr_fact, wr_en;
  logic     code_bad, code_take;
  logic     alloc_bad, alloc_take;
  logic [SEG_W:0] new_total;
  logic [SEG_W-1:0] old_alloc;
  logic     old_en;
  int unsigned lim_i;

  assign sel = cfg_sel_e'(cfg_sel);

  always_comb begin
    lim_i = chans_of_code(code_q);
    if (lim_i > MAX_CH) lim_i = MAX_CH;
    ch_limit = (CH_W+1)'(lim_i);
  end

  assign ch_ok    = ({1'b0, cfg_ch} < ch_limit);
  assign wr_code  = cfg_we && (sel == SEL_CODE);
  assign wr_alloc = cfg_we && (sel == SEL_ALLOC) && ch_ok;
  assign wr_fact  = cfg_we && (sel == SEL_FACT)  && ch_ok;
  assign wr_en    = cfg_we && (sel == SEL_EN)    && ch_ok;

  assign old_alloc = ch_ok ? alloc_q[cfg_ch] : '0;
  assign old_en    = ch_ok ? en_q[cfg_ch]    : 1'b0;

  // Code: first legal write locks; later writes ignored silently.
  assign code_bad  = wr_code && !lock_q && (cfg_data[2:0] > CODE_MAX);
  assign code_take = wr_code && !lock_q && !code_bad;

  // Allocation: the new total replaces this channel's old share.
  assign new_total  = total_q - {1'b0, old_alloc} + {1'b0, cfg_data};
  assign alloc_bad  = old_en
                   || (int'(cfg_data) > int'(cap_of_code(code_q)))
                   || (int'(new_total) > POOL_SEGS);
  assign alloc_take = wr_alloc && !alloc_bad;

  assign ev_chan  = cfg_we && (sel != SEL_CODE) && !ch_ok;
  assign ev_alloc = code_bad || (wr_alloc && alloc_bad);

  for (genvar i = 0; i < MAX_CH; i++) begin : g_load
    assign load_vec[i] = wr_en && cfg_data[0] && (cfg_ch == CH_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= CODE_RESET;
      lock_q  <= 1'b0;
      alloc_q <= '0;
      fact_q  <= '0;
      en_q    <= '0;
      total_q <= '0;
    end else begin
      if (code_take) begin
        code_q <= cfg_data[2:0];
        lock_q <= 1'b1;
      end
      if (alloc_take) begin
        alloc_q[cfg_ch] <= cfg_data;
        total_q         <= new_total;
      end
      if (wr_fact) fact_q[cfg_ch] <= cfg_data[FACT_W-1:0];
      if (wr_en)   en_q[cfg_ch]   <= cfg_data[0];
    end
  end

  assign code   = code_q;
  assign locked = lock_q;
  assign alloc  = alloc_q;
  assign factor = fact_q;
  assign en     = en_q;
  assign total  = total_q;

endmodule

// File: rtl/seg_ctr.sv
module seg_ctr #(
  parameter int MAX_CH = 64,
  parameter int CH_W   = 6,
  parameter int SEG_W  = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [MAX_CH-1:0]            en,
  input  logic [MAX_CH-1:0][SEG_W-1:0] alloc,
  input  logic [MAX_CH-1:0]            load_vec,
  input  logic [CH_W:0]                ch_limit,
  input  logic                         cons_vld,
  input  logic [CH_W-1:0]              cons_ch,
  input  logic                         rel_vld,
  input  logic [CH_W-1:0]              rel_ch,
  output logic [MAX_CH-1:0][SEG_W-1:0] free,
  output logic                         ev_chan,
  output logic                         ev_ovf,
  output logic                         ev_unf
);

  logic cons_ok, rel_ok;
  logic [MAX_CH-1:0] ovf_vec, unf_vec;
  logic [MAX_CH-1:0][SEG_W-1:0] free_q;

  assign cons_ok = cons_vld && ({1'b0, cons_ch} < ch_limit);
  assign rel_ok  = rel_vld  && ({1'b0, rel_ch}  < ch_limit);

  for (genvar i = 0; i < MAX_CH; i++) begin : g_ch
    logic take, give, at_zero, at_full;
    assign take    = cons_ok && (cons_ch == CH_W'(i)) && en[i] && !load_vec[i];
    assign give    = rel_ok  && (rel_ch  == CH_W'(i)) && en[i] && !load_vec[i];
    assign at_zero = (free_q[i] == '0);
    assign at_full = (free_q[i] >= alloc[i]);
    // A simultaneous take and give on one channel cancel out.
    assign ovf_vec[i] = take && !give && at_zero;
    assign unf_vec[i] = give && !take && at_full;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        free_q[i] <= '0;
      end else if (load_vec[i]) begin
        free_q[i] <= alloc[i];
      end else if (take && !give && !at_zero) begin
        free_q[i] <= free_q[i] - 1'b1;
      end else if (give && !take && !at_full) begin
        free_q[i] <= free_q[i] + 1'b1;
      end
    end
  end

  assign free    = free_q;
  assign ev_chan = (cons_vld && !cons_ok) || (rel_vld && !rel_ok);
  assign ev_ovf  = |ovf_vec;
  assign ev_unf  = |unf_vec;

endmodule

// File: rtl/seg_thresh.sv
module seg_thresh
  import segalloc_pkg::*;
#(
  parameter int MAX_CH = 64,
  parameter int FACT_W = 5,
  parameter int SEG_W  = 9,
  parameter int THR_W  = 9
) (
  input  logic [MAX_CH-1:0][SEG_W-1:0]  alloc,
  input  logic [MAX_CH-1:0][FACT_W-1:0] factor,
  input  logic [MAX_CH-1:0]             en,
  input  logic [MAX_CH-1:0][SEG_W-1:0]  free,
  output logic [MAX_CH-1:0][THR_W-1:0]  thr,
  output logic [MAX_CH-1:0]             bp
);

  localparam int CMP_W = (THR_W > SEG_W) ? THR_W : SEG_W;

  for (genvar i = 0; i < MAX_CH; i++) begin : g_thr
    logic [8:0]       m9;
    logic [CMP_W-1:0] free_x, thr_x;
    assign m9     = 9'(alloc[i]);
    assign thr[i] = THR_W'(factor[i]) << scale_shift(m9);
    assign free_x = CMP_W'(free[i]);
    assign thr_x  = CMP_W'(thr[i]);
    assign bp[i]  = en[i] && (free_x <= thr_x);
  end

endmodule

// File: rtl/seg_alloc_top.sv
module seg_alloc_top #(
  parameter int MAX_CH    = 64,
  parameter int FACT_W    = 5,
  parameter int POOL_SEGS = 508,
  localparam int CH_W     = (MAX_CH > 1) ? $clog2(MAX_CH) : 1,
  localparam int SEG_W    = $clog2(POOL_SEGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [SEG_W-1:0]  cfg_data,
  input  logic              cons_vld,
  input  logic [CH_W-1:0]   cons_ch,
  input  logic              rel_vld,
  input  logic [CH_W-1:0]   rel_ch,
  output logic [MAX_CH-1:0] bp,
  output logic              err_chan,
  output logic              err_alloc,
  output logic              err_ovf,
  output logic              err_unf
);

  localparam int THR_W = FACT_W + 4;

  logic [2:0]                    code;
  logic                          locked;
  logic [CH_W:0]                 ch_limit;
  logic [MAX_CH-1:0][SEG_W-1:0]  alloc;
  logic [MAX_CH-1:0][FACT_W-1:0] factor;
  logic [MAX_CH-1:0]             en;
  logic [MAX_CH-1:0]             load_vec;
  logic [SEG_W:0]                total;
  logic [MAX_CH-1:0][SEG_W-1:0]  free;
  logic [MAX_CH-1:0][THR_W-1:0]  thr;
  logic cfg_ev_chan, cfg_ev_alloc, ctr_ev_chan, ev_ovf, ev_unf;

  seg_cfg #(
    .MAX_CH(MAX_CH), .FACT_W(FACT_W), .POOL_SEGS(POOL_SEGS),
    .CH_W(CH_W), .SEG_W(SEG_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_ch(cfg_ch), .cfg_data(cfg_data), .code(code), .locked(locked),
    .ch_limit(ch_limit), .alloc(alloc), .factor(factor), .en(en),
    .load_vec(load_vec), .total(total), .ev_chan(cfg_ev_chan),
    .ev_alloc(cfg_ev_alloc)
  );

  seg_ctr #(
    .MAX_CH(MAX_CH), .CH_W(CH_W), .SEG_W(SEG_W)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .en(en), .alloc(alloc), .load_vec(load_vec),
    .ch_limit(ch_limit), .cons_vld(cons_vld), .cons_ch(cons_ch),
    .rel_vld(rel_vld), .rel_ch(rel_ch), .free(free),
    .ev_chan(ctr_ev_chan), .ev_ovf(ev_ovf), .ev_unf(ev_unf)
  );

  seg_thresh #(
    .MAX_CH(MAX_CH), .FACT_W(FACT_W), .SEG_W(SEG_W), .THR_W(THR_W)
  ) u_thr (
    .alloc(alloc), .factor(factor), .en(en), .free(free),
    .thr(thr), .bp(bp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_chan  <= 1'b0;
      err_alloc <= 1'b0;
      err_ovf   <= 1'b0;
      err_unf   <= 1'b0;
    end else begin
      err_chan  <= cfg_ev_chan || ctr_ev_chan;
      err_alloc <= cfg_ev_alloc;
      err_ovf   <= ev_ovf;
      err_unf   <= ev_unf;
    end
  end

endmodule

// File: rtl/seg_alloc_chk.sv
module seg_alloc_chk #(
  parameter int MAX_CH    = 64,
  parameter int POOL_SEGS = 508,
  parameter int CH_W      = 6,
  parameter int SEG_W     = 9
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cons_vld,
  input logic [CH_W-1:0]              cons_ch,
  input logic                         rel_vld,
  input logic [CH_W-1:0]              rel_ch,
  input logic [2:0]                   code,
  input logic                         locked,
  input logic [CH_W:0]                ch_limit,
  input logic [SEG_W:0]               total,
  input logic [MAX_CH-1:0]            en,
  input logic [MAX_CH-1:0]            load_vec,
  input logic [MAX_CH-1:0][SEG_W-1:0] alloc,
  input logic [MAX_CH-1:0][SEG_W-1:0] free,
  input logic [MAX_CH-1:0]            bp,
  input logic                         err_chan,
  input logic                         err_ovf,
  input logic                         err_unf
);

  logic cons_in, cons_solo, rel_solo;
  assign cons_in   = cons_vld && ({1'b0, cons_ch} < ch_limit);
  assign cons_solo = cons_in && en[cons_ch] && !load_vec[cons_ch]
                  && !(rel_vld && rel_ch == cons_ch);
  assign rel_solo  = rel_vld && ({1'b0, rel_ch} < ch_limit) && en[rel_ch]
                  && !load_vec[rel_ch] && !(cons_vld && cons_ch == rel_ch);

  assert_pool_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(total) <= POOL_SEGS);

  assert_code_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(code));

  assert_chan_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_vld && !cons_in) |=> err_chan);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_solo && free[cons_ch] == '0) |=> err_ovf);

  assert_consume_dec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_solo && free[cons_ch] != '0)
      |=> free[$past(cons_ch)] == $past(free[cons_ch]) - 1'b1);

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_solo && free[rel_ch] >= alloc[rel_ch]) |=> err_unf);

  assert_quiet_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bp & ~en) == '0);

  assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cons_vld && !rel_vld) |=> (!err_ovf && !err_unf));

endmodule

bind seg_alloc_top seg_alloc_chk #(
  .MAX_CH(MAX_CH), .POOL_SEGS(POOL_SEGS), .CH_W(CH_W), .SEG_W(SEG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cons_vld(cons_vld), .cons_ch(cons_ch),
  .rel_vld(rel_vld), .rel_ch(rel_ch), .code(code), .locked(locked),
  .ch_limit(ch_limit), .total(total), .en(en), .load_vec(load_vec),
  .alloc(alloc), .free(free), .bp(bp), .err_chan(err_chan),
  .err_ovf(err_ovf), .err_unf(err_unf)
);

// File: tb/test_seg_alloc_top.sv
module test_seg_alloc_top;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [5:0]  cfg_ch = '0;
  logic [8:0]  cfg_data = '0;
  logic        cons_vld = 1'b0;
  logic [5:0]  cons_ch = '0;
  logic        rel_vld = 1'b0;
  logic [5:0]  rel_ch = '0;
  logic [NCH-1:0] bp;
  logic err_chan, err_alloc, err_ovf, err_unf;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;
  logic e_chan, e_alloc, e_ovf, e_unf;

  seg_alloc_top i_seg_alloc_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_ch(cfg_ch), .cfg_data(cfg_data), .cons_vld(cons_vld),
    .cons_ch(cons_ch), .rel_vld(rel_vld), .rel_ch(rel_ch), .bp(bp),
    .err_chan(err_chan), .err_alloc(err_alloc), .err_ovf(err_ovf),
    .err_unf(err_unf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic grab();
    e_chan = err_chan; e_alloc = err_alloc; e_ovf = err_ovf; e_unf = err_unf;
  endtask

  // Drive one write at a falling edge; errors are sampled one cycle later.
  task automatic wr(input int sel, input int ch, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_ch = 6'(ch); cfg_data = 9'(data);
    @(negedge clk);
    cfg_we = 1'b0;
    grab();
  endtask

  task automatic consume(input int ch);
    @(negedge clk);
    cons_vld = 1'b1; cons_ch = 6'(ch);
    @(negedge clk);
    cons_vld = 1'b0;
    grab();
  endtask

  task automatic release_seg(input int ch);
    @(negedge clk);
    rel_vld = 1'b1; rel_ch = 6'(ch);
    @(negedge clk);
    rel_vld = 1'b0;
    grab();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 bp after reset", bp, 0);
    chk("R1 errors after reset", {err_chan, err_alloc, err_ovf, err_unf}, 0);
  endtask

  task automatic t_code();
    wr(2, 15, 1); chk("R1 ch15 legal under reset code", e_chan, 0);
    wr(2, 16, 1); chk("R3 ch16 illegal under reset code", e_chan, 1);
    @(negedge clk);
    chk("R11 err_chan is a one-cycle pulse", err_chan, 0);
    wr(0, 0, 7);  chk("R2 code 7 rejected", e_alloc, 1);
    wr(2, 15, 0); chk("R2 rejected code left 16 channels", e_chan, 0);
    wr(0, 0, 1);  chk("R2 code 1 accepted", e_alloc, 0);
    wr(0, 0, 3);  chk("R2 later code write silent", e_alloc, 0);
    wr(2, 4, 1);  chk("R3 ch4 illegal under locked code 1", e_chan, 1);
    wr(2, 3, 0);  chk("R3 ch3 legal under code 1", e_chan, 0);
  endtask

  task automatic t_threshold();
    wr(1, 0, 257); chk("R5 cap 256 exceeded", e_alloc, 1);
    wr(1, 0, 64);  chk("R5 alloc 64 accepted", e_alloc, 0);
    wr(2, 0, 4);
    wr(3, 0, 1);
    chk("R10 bp low at full free", bp[0], 0);
    for (int k = 0; k < 47; k++) consume(0);
    chk("R10 free 17 above thr 16", bp[0], 0);
    consume(0);
    chk("R9 M=64 factor 4 threshold 16", bp[0], 1);
    release_seg(0);
    chk("R8 release raises free to 17", bp[0], 0);
    chk("R8 legal release no error", e_unf, 0);
    consume(0);
    chk("R10 bp back at 16", bp[0], 1);
    wr(2, 0, 3);
    chk("R10 factor 3 thr 12 drops bp", bp[0], 0);
  endtask

  task automatic t_pool();
    wr(1, 1, 256); chk("R5 total 320 ok", e_alloc, 0);
    wr(1, 2, 189); chk("R5 total 509 rejected", e_alloc, 1);
    wr(1, 2, 188); chk("R5 total 508 ok", e_alloc, 0);
    wr(1, 3, 1);   chk("R5 pool full", e_alloc, 1);
  endtask

  task automatic t_enabled_alloc();
    int cnt;
    wr(1, 0, 10);  chk("R4 alloc write to enabled channel", e_alloc, 1);
    wr(2, 0, 31);
    chk("R10 factor 31 thr 124 raises bp", bp[0], 1);
    wr(3, 0, 0);
    chk("R6 disabled channel no bp", bp[0], 0);
    wr(2, 0, 0);
    wr(3, 0, 1);
    cnt = 0;
    for (int k = 0; k < 600; k++) begin
      consume(0);
      if (e_ovf) break;
      cnt++;
    end
    chk("R6 R4 enable reloads unchanged M=64", cnt, 64);
    chk("R7 consume at zero overflows", e_ovf, 1);
    chk("R10 factor 0 bp at zero free", bp[0], 1);
  endtask

  task automatic t_release();
    release_seg(1); chk("R8 release on disabled silent", e_unf, 0);
    wr(3, 1, 1);
    release_seg(1); chk("R8 release at M underflows", e_unf, 1);
    consume(2);     chk("R7 consume on disabled silent", e_ovf, 0);
    chk("R7 disabled channel no bp", bp[2], 0);
    consume(5);     chk("R3 consume index 5 out of range", e_chan, 1);
    release_seg(4); chk("R3 release index 4 out of range", e_chan, 1);
  endtask

  task automatic t_scale();
    int ms[8] = '{31, 32, 63, 64, 127, 128, 255, 256};
    int ex[8] = '{0, 1, 0, 1, 0, 1, 0, 1};
    wr(3, 1, 0); wr(1, 1, 0);
    wr(1, 2, 0);
    chk("R5 shrinking allocations accepted", e_alloc, 0);
    wr(2, 3, 16);
    foreach (ms[k]) begin
      wr(3, 3, 0);
      wr(1, 3, ms[k]);
      chk("R5 boundary alloc accepted", e_alloc, 0);
      wr(3, 3, 1);
      chk($sformatf("R9 scale edge M=%0d factor 16", ms[k]), bp[3], ex[k]);
    end
  endtask

  task automatic t_single();
    do_reset();
    t_reset();
    wr(0, 0, 0);   chk("R2 code 0 accepted", e_alloc, 0);
    wr(2, 1, 1);   chk("R3 ch1 illegal with one channel", e_chan, 1);
    wr(1, 0, 508); chk("R5 full pool to one channel", e_alloc, 0);
    wr(2, 0, 31);
    wr(3, 0, 1);
    for (int k = 0; k < 11; k++) consume(0);
    chk("R9 free 497 above thr 496", bp[0], 0);
    consume(0);
    chk("R9 M=508 scale 16 thr 496", bp[0], 1);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_code();
    t_threshold();
    t_pool();
    t_enabled_alloc();
    t_release();
    t_scale();
    t_single();
    finish_run();
  end

endmodule